// File: doc/BRIEF.md
# Interrupt presenter

This block sits beside one processor and decides which single interrupt that processor is offered next. Source controllers offer interrupts to it, each with a source number, a priority and the identity of the offering controller. The presenter keeps one pending slot. A more favoured offer pushes the current occupant out and hands it back to its owner. It drives one level-sensitive interrupt line. It also contains its own inter-processor interrupt (IPI) source, which has a programmable priority.

The processor talks to it through five register operations: accept, poll, set processor priority, set IPI priority and end-of-interrupt. Accept and poll return the 32-bit accept word. The processor priority sits in bits 31:24 and the pending source number in bits 23:0. Every operation finishes in one cycle. The block answers the source side with one-cycle strobes: a refusal of the offer just made, an eviction of a pending source, an end-of-interrupt notice and a request that all sources resend.

Top module: `irq_presenter`

## Requirements
- R1: After synchronous reset the accept word is 0 (processor priority 0x00, no source pending). The pending priority and the IPI priority are both 0xFF and irq_out is low. No strobe is active.
- R2: Lower numbers are more favoured. An offer is refused, and nack_valid pulses with its source and owner, when its priority is not strictly below the processor priority. It is also refused when a source is already pending with a priority equal to or below the offered one.
- R3: An offer that is not refused replaces the pending entry and raises irq_out. If the previous occupant came from a source controller, rej_valid pulses with its source number and owner. A displaced IPI is dropped without a reject.
- R4: When an offer and a register operation arrive in the same cycle, the operation is performed and the offer is refused through the nack strobe.
- R5: Accept (op_code 0) returns the accept word on rd_word. It then lowers irq_out and moves the pending priority into the processor priority field. It clears the source number, sets the pending priority to 0xFF and forgets the owner.
- R6: Poll (op_code 1) returns the accept word on rd_word and the IPI priority on rd_ipi_prio, and changes no state.
- R7: Set processor priority (op_code 2, value in op_data[7:0]) to a more favoured value affects an existing pending entry only when that entry's priority is equal to or above the new value. In that case the entry is dropped, irq_out falls, and an owned entry is rejected to its owner. A pending entry with a priority below the new value is kept.
- R8: Set processor priority to an equal or less favoured value while nothing is pending pulses resend_req. In the same cycle the IPI is loaded if its priority is below the new processor priority.
- R9: Set IPI priority (op_code 3, value in op_data[7:0]) stores the value. When the value is below the processor priority and no pending entry has a priority at or below it, the IPI becomes pending as source 2 with that priority. irq_out rises and any owned occupant is rejected.
- R10: End-of-interrupt (op_code 4) copies op_data[31:24] into the processor priority. It pulses eoi_valid with op_data[23:0] and, if nothing is pending, performs the resend of R8.
- R11: Every output is registered. Strobes and read data appear in the cycle after the input that caused them, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | A source controller offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_owner | input | 4 | Identifier of the offering source controller |
| op_valid | input | 1 | Register operation this cycle |
| op_code | input | 3 | 0 accept, 1 poll, 2 set processor priority, 3 set IPI priority, 4 end-of-interrupt |
| op_data | input | 32 | Write data of the operation |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read data valid strobe |
| rd_word | output | 32 | Accept word returned by accept or poll |
| rd_ipi_prio | output | 8 | IPI priority returned alongside the word |
| nack_valid | output | 1 | The offer of the previous cycle was refused |
| nack_src | output | 24 | Source number of the refused offer |
| nack_owner | output | 4 | Owner of the refused offer |
| rej_valid | output | 1 | A pending source was evicted back to its owner |
| rej_src | output | 24 | Source number of the evicted entry |
| rej_owner | output | 4 | Owner of the evicted entry |
| eoi_valid | output | 1 | End-of-interrupt notice to the sources |
| eoi_src | output | 24 | Source number being completed |
| resend_req | output | 1 | Request that all sources re-offer |

## Verification
The checker enforces these on every cycle:
- the reset state;
- the line level following the presence of a pending source number;
- an empty slot always carrying pending priority 0xFF;
- every offer ending either refused or latched;
- accept returning the previous word and emptying the slot;
- poll leaving all state untouched;
- every eviction naming the entry that was pending and owned.

Priority ordering needs the bench's reference model and directed scenarios to show. That covers ties between offers and the pending entry, when an IPI takes the slot, and resend after end-of-interrupt or a priority relaxation. It also covers preemption of an IPI without a reject, and an offer colliding with an operation.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int OWN_W  = 4;
    localparam int WORD_W = PRIO_W + SRC_W;

    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_SRC   = SRC_W'(2);

    typedef enum logic [2:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_CPPR = 3'd2,
        OP_SET_IPI  = 3'd3,
        OP_EOI      = 3'd4
    } op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xisr;
        logic [PRIO_W-1:0] pprio;
        logic [PRIO_W-1:0] ipi;
        logic              own_vld;
        logic [OWN_W-1:0]  own_id;
        logic              irq;
    } pres_t;

    typedef struct packed {
        logic             vld;
        logic [SRC_W-1:0] src;
        logic [OWN_W-1:0] owner;
    } note_t;

    typedef struct packed {
        pres_t st;
        note_t evict;
    } step_t;

    localparam pres_t RESET_ST = '{
        cppr:    '0,
        xisr:    '0,
        pprio:   PRIO_NONE,
        ipi:     PRIO_NONE,
        own_vld: 1'b0,
        own_id:  '0,
        irq:     1'b0
    };

    function automatic logic favours(input logic [PRIO_W-1:0] a,
                                     input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction

    function automatic logic [WORD_W-1:0] acc_word(input pres_t s);
        return {s.cppr, s.xisr};
    endfunction

    function automatic note_t evict_of(input pres_t s);
        note_t n;
        n.vld   = (s.xisr != '0) && s.own_vld;
        n.src   = s.xisr;
        n.owner = s.own_id;
        return n;
    endfunction

    // Install the IPI unless an equal or more favoured entry already waits.
    function automatic step_t ipi_check(input pres_t s);
        step_t r;
        r.st    = s;
        r.evict = '0;
        if (!((s.xisr != '0) && !favours(s.ipi, s.pprio))) begin
            r.evict      = evict_of(s);
            r.st.xisr    = IPI_SRC;
            r.st.pprio   = s.ipi;
            r.st.own_vld = 1'b0;
            r.st.irq     = 1'b1;
        end
        return r;
    endfunction

    function automatic step_t resend_ipi(input pres_t s);
        step_t r;
        if (favours(s.ipi, s.cppr)) begin
            r = ipi_check(s);
        end else begin
            r.st    = s;
            r.evict = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/irqp_offer_unit.sv
module irqp_offer_unit
    import irqp_pkg::*;
(
    input  pres_t                cur,
    input  logic                 offer_vld,
    input  logic [SRC_W-1:0]     src,
    input  logic [PRIO_W-1:0]    prio,
    input  logic [OWN_W-1:0]     owner,
    output pres_t                nxt,
    output note_t                nack,
    output note_t                evict
);

    logic refuse;

    assign refuse = !favours(prio, cur.cppr) ||
                    ((cur.xisr != '0) && !favours(prio, cur.pprio));

    always_comb begin
        nxt   = cur;
        nack  = '0;
        evict = '0;
        if (offer_vld) begin
            if (refuse) begin
                nack.vld   = 1'b1;
                nack.src   = src;
                nack.owner = owner;
            end else begin
                evict       = evict_of(cur);
                nxt.xisr    = src;
                nxt.pprio   = prio;
                nxt.own_vld = 1'b1;
                nxt.own_id  = owner;
                nxt.irq     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqp_op_unit.sv
module irqp_op_unit
    import irqp_pkg::*;
(
    input  pres_t                cur,
    input  logic                 op_vld,
    input  op_e                  code,
    input  logic [WORD_W-1:0]    data,
    output pres_t                nxt,
    output note_t                evict,
    output note_t                eoi,
    output logic                 resend,
    output logic                 rd_stb
);

    logic [PRIO_W-1:0] low_val;
    step_t             stp;

    assign low_val = data[PRIO_W-1:0];

    always_comb begin
        nxt    = cur;
        evict  = '0;
        eoi    = '0;
        resend = 1'b0;
        rd_stb = 1'b0;
        stp    = '0;
        if (op_vld) begin
            unique case (code)
                OP_ACCEPT: begin
                    rd_stb      = 1'b1;
                    nxt.irq     = 1'b0;
                    nxt.cppr    = cur.pprio;
                    nxt.xisr    = '0;
                    nxt.pprio   = PRIO_NONE;
                    nxt.own_vld = 1'b0;
                end
                OP_POLL: begin
                    rd_stb = 1'b1;
                end
                OP_SET_CPPR: begin
                    nxt.cppr = low_val;
                    if (favours(low_val, cur.cppr)) begin
                        if ((cur.xisr != '0) && !favours(cur.pprio, low_val)) begin
                            evict       = evict_of(cur);
                            nxt.xisr    = '0;
                            nxt.pprio   = PRIO_NONE;
                            nxt.own_vld = 1'b0;
                            nxt.irq     = 1'b0;
                        end
                    end else if (cur.xisr == '0) begin
                        stp    = resend_ipi(nxt);
                        nxt    = stp.st;
                        evict  = stp.evict;
                        resend = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    nxt.ipi = low_val;
                    if (favours(low_val, cur.cppr)) begin
                        stp   = ipi_check(nxt);
                        nxt   = stp.st;
                        evict = stp.evict;
                    end
                end
                OP_EOI: begin
                    nxt.cppr = data[WORD_W-1:SRC_W];
                    eoi.vld  = 1'b1;
                    eoi.src  = data[SRC_W-1:0];
                    if (cur.xisr == '0) begin
                        stp    = resend_ipi(nxt);
                        nxt    = stp.st;
                        evict  = stp.evict;
                        resend = 1'b1;
                    end
                end
                default: begin
                    nxt = cur;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 offer_valid,
    input  logic [SRC_W-1:0]     offer_src,
    input  logic [PRIO_W-1:0]    offer_prio,
    input  logic [OWN_W-1:0]     offer_owner,
    input  logic                 op_valid,
    input  logic [2:0]           op_code,
    input  logic [WORD_W-1:0]    op_data,
    output logic                 irq_out,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_word,
    output logic [PRIO_W-1:0]    rd_ipi_prio,
    output logic                 nack_valid,
    output logic [SRC_W-1:0]     nack_src,
    output logic [OWN_W-1:0]     nack_owner,
    output logic                 rej_valid,
    output logic [SRC_W-1:0]     rej_src,
    output logic [OWN_W-1:0]     rej_owner,
    output logic                 eoi_valid,
    output logic [SRC_W-1:0]     eoi_src,
    output logic                 resend_req
);

    pres_t st_q, st_d;
    pres_t off_nxt, op_nxt;
    note_t off_nack, off_evict, op_evict, op_eoi;
    note_t nack_d, rej_d;
    note_t nack_q, rej_q, eoi_q;
    logic  op_resend, op_rd;
    logic  rd_valid_q, resend_q;
    logic [WORD_W-1:0] rd_word_q;
    logic [PRIO_W-1:0] rd_ipi_q;

    irqp_offer_unit u_offer (
        .cur       (st_q),
        .offer_vld (offer_valid),
        .src       (offer_src),
        .prio      (offer_prio),
        .owner     (offer_owner),
        .nxt       (off_nxt),
        .nack      (off_nack),
        .evict     (off_evict)
    );

    irqp_op_unit u_op (
        .cur    (st_q),
        .op_vld (op_valid),
        .code   (op_e'(op_code)),
        .data   (op_data),
        .nxt    (op_nxt),
        .evict  (op_evict),
        .eoi    (op_eoi),
        .resend (op_resend),
        .rd_stb (op_rd)
    );

    // A register operation owns the cycle; a colliding offer is refused.
    always_comb begin
        if (op_valid) begin
            st_d         = op_nxt;
            rej_d        = op_evict;
            nack_d.vld   = offer_valid;
            nack_d.src   = offer_src;
            nack_d.owner = offer_owner;
        end else begin
            st_d   = off_nxt;
            rej_d  = off_evict;
            nack_d = off_nack;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= RESET_ST;
            nack_q     <= '0;
            rej_q      <= '0;
            eoi_q      <= '0;
            resend_q   <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_word_q  <= '0;
            rd_ipi_q   <= '0;
        end else begin
            st_q       <= st_d;
            nack_q     <= nack_d;
            rej_q      <= rej_d;
            eoi_q      <= op_valid ? op_eoi : '0;
            resend_q   <= op_valid && op_resend;
            rd_valid_q <= op_valid && op_rd;
            if (op_valid && op_rd) begin
                rd_word_q <= acc_word(st_q);
                rd_ipi_q  <= st_q.ipi;
            end
        end
    end

    assign irq_out     = st_q.irq;
    assign rd_valid    = rd_valid_q;
    assign rd_word     = rd_word_q;
    assign rd_ipi_prio = rd_ipi_q;
    assign nack_valid  = nack_q.vld;
    assign nack_src    = nack_q.src;
    assign nack_owner  = nack_q.owner;
    assign rej_valid   = rej_q.vld;
    assign rej_src     = rej_q.src;
    assign rej_owner   = rej_q.owner;
    assign eoi_valid   = eoi_q.vld;
    assign eoi_src     = eoi_q.src;
    assign resend_req  = resend_q;

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker
    import irqp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              offer_valid,
    input logic [SRC_W-1:0]  offer_src,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic              irq_out,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_word,
    input logic              nack_valid,
    input logic              rej_valid,
    input logic [SRC_W-1:0]  rej_src,
    input pres_t             st
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!irq_out && st.cppr == '0 && st.xisr == '0 &&
                 st.pprio == PRIO_NONE && st.ipi == PRIO_NONE &&
                 !rej_valid && !nack_valid && !rd_valid));

    a_r3_line_follows_slot: assert property (@(posedge clk) disable iff (rst)
        irq_out == (st.xisr != '0));

    a_r5_empty_slot_prio: assert property (@(posedge clk) disable iff (rst)
        (st.xisr == '0) |-> (st.pprio == PRIO_NONE));

    a_r2_offer_resolved: assert property (@(posedge clk) disable iff (rst)
        offer_valid |=> (nack_valid || st.xisr == $past(offer_src)));

    a_r5_accept_word: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd0) |=>
            (rd_valid && !irq_out && st.xisr == '0 &&
             rd_word == {$past(st.cppr), $past(st.xisr)}));

    a_r6_poll_no_change: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1) |=> $stable(st));

    a_r3_evict_owned: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> ($past(st.own_vld) && rej_src == $past(st.xisr)));

endmodule

bind irq_presenter irqp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .irq_out     (irq_out),
    .rd_valid    (rd_valid),
    .rd_word     (rd_word),
    .nack_valid  (nack_valid),
    .rej_valid   (rej_valid),
    .rej_src     (rej_src),
    .st          (st_q)
);

// File: tb/test_irq_presenter.sv
`timescale 1ns/1ps
module test_irq_presenter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic [3:0]  offer_owner = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        irq_out, rd_valid, nack_valid, rej_valid, eoi_valid, resend_req;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi_prio;
    logic [23:0] nack_src, rej_src, eoi_src;
    logic [3:0]  nack_owner, rej_owner;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_presenter i_irq_presenter (
        .clk(clk), .rst(rst),
        .offer_valid(offer_valid), .offer_src(offer_src),
        .offer_prio(offer_prio), .offer_owner(offer_owner),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .irq_out(irq_out), .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_ipi_prio(rd_ipi_prio),
        .nack_valid(nack_valid), .nack_src(nack_src), .nack_owner(nack_owner),
        .rej_valid(rej_valid), .rej_src(rej_src), .rej_owner(rej_owner),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_cppr, m_xisr, m_pp, m_ipi, m_ov, m_oid, m_irq;
    int e_rdv, e_rd, e_rdi, e_nv, e_ns, e_no, e_rv, e_rs, e_ro, e_ev, e_es, e_res;

    task automatic m_evict();
        if (m_xisr != 0 && m_ov != 0) begin
            e_rv = 1; e_rs = m_xisr; e_ro = m_oid;
        end
    endtask

    task automatic m_ipi_check();
        if (m_xisr != 0 && m_pp <= m_ipi) return;
        m_evict();
        m_xisr = 2; m_pp = m_ipi; m_ov = 0; m_irq = 1;
    endtask

    task automatic m_resend();
        if (m_ipi < m_cppr) m_ipi_check();
        e_res = 1;
    endtask

    always @(posedge clk) begin
        int n, old;
        e_rdv = 0; e_nv = 0; e_rv = 0; e_ev = 0; e_res = 0;
        if (rst) begin
            m_cppr = 0; m_xisr = 0; m_pp = 255; m_ipi = 255;
            m_ov = 0; m_oid = 0; m_irq = 0;
            e_rd = 0; e_rdi = 0;
        end else if (op_valid) begin
            if (offer_valid) begin
                e_nv = 1; e_ns = offer_src; e_no = offer_owner;
            end
            n = op_data[7:0];
            case (op_code)
                3'd0: begin
                    e_rdv = 1; e_rd = (m_cppr << 24) | m_xisr; e_rdi = m_ipi;
                    m_cppr = m_pp; m_xisr = 0; m_pp = 255; m_ov = 0; m_irq = 0;
                end
                3'd1: begin
                    e_rdv = 1; e_rd = (m_cppr << 24) | m_xisr; e_rdi = m_ipi;
                end
                3'd2: begin
                    old = m_cppr; m_cppr = n;
                    if (n < old) begin
                        if (m_xisr != 0 && n <= m_pp) begin
                            m_evict();
                            m_xisr = 0; m_pp = 255; m_irq = 0; m_ov = 0;
                        end
                    end else if (m_xisr == 0) begin
                        m_resend();
                    end
                end
                3'd3: begin
                    m_ipi = n;
                    if (n < m_cppr) m_ipi_check();
                end
                3'd4: begin
                    m_cppr = op_data[31:24];
                    e_ev = 1; e_es = op_data[23:0];
                    if (m_xisr == 0) m_resend();
                end
                default: ;
            endcase
        end else if (offer_valid) begin
            if (offer_prio >= m_cppr || (m_xisr != 0 && m_pp <= offer_prio)) begin
                e_nv = 1; e_ns = offer_src; e_no = offer_owner;
            end else begin
                m_evict();
                m_xisr = offer_src; m_pp = offer_prio;
                m_ov = 1; m_oid = offer_owner; m_irq = 1;
            end
        end
    end

    // Per-cycle comparison against the model (R11: outputs one cycle late).
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 irq_out", {31'd0, irq_out}, m_irq);
            chk("R11 rd_valid", {31'd0, rd_valid}, e_rdv);
            if (e_rdv != 0) begin
                chk("R5 rd_word", rd_word, e_rd);
                chk("R6 rd_ipi_prio", {24'd0, rd_ipi_prio}, e_rdi);
            end
            chk("R2 nack_valid", {31'd0, nack_valid}, e_nv);
            if (e_nv != 0) begin
                chk("R2 nack_src", {8'd0, nack_src}, e_ns);
                chk("R2 nack_owner", {28'd0, nack_owner}, e_no);
            end
            chk("R3 rej_valid", {31'd0, rej_valid}, e_rv);
            if (e_rv != 0) begin
                chk("R3 rej_src", {8'd0, rej_src}, e_rs);
                chk("R3 rej_owner", {28'd0, rej_owner}, e_ro);
            end
            chk("R10 eoi_valid", {31'd0, eoi_valid}, e_ev);
            if (e_ev != 0) chk("R10 eoi_src", {8'd0, eoi_src}, e_es);
            chk("R8 resend_req", {31'd0, resend_req}, e_res);
        end
    end

    task automatic step(input logic ov, input logic [23:0] os, input logic [7:0] opr,
                        input logic [3:0] oo, input logic qv, input logic [2:0] qc,
                        input logic [31:0] qd);
        offer_valid = ov; offer_src = os; offer_prio = opr; offer_owner = oo;
        op_valid = qv; op_code = qc; op_data = qd;
        @(negedge clk);
        offer_valid = 1'b0; op_valid = 1'b0;
    endtask

    task automatic offer(input logic [23:0] s, input logic [7:0] p, input logic [3:0] o);
        step(1'b1, s, p, o, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic op(input logic [2:0] c, input logic [31:0] d);
        step(1'b0, 24'd0, 8'd0, 4'd0, 1'b1, c, d);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=%0d expected=finished", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        op(3'd1, 32'd0);
        chk("R1 reset word", rd_word, 32'h0);
        chk("R1 reset ipi prio", {24'd0, rd_ipi_prio}, 32'hFF);
        chk("R1 reset line", {31'd0, irq_out}, 32'd0);

        op(3'd2, 32'h0000_00FF);
        chk("R8 resend on relax", {31'd0, resend_req}, 32'd1);

        offer(24'h40, 8'd5, 4'd3);
        chk("R3 offer taken line", {31'd0, irq_out}, 32'd1);

        offer(24'h41, 8'd5, 4'd2);
        chk("R2 tie refused", {31'd0, nack_valid}, 32'd1);
        chk("R2 tie refused src", {8'd0, nack_src}, 32'h41);

        offer(24'h42, 8'd3, 4'd1);
        chk("R3 evict src", {8'd0, rej_src}, 32'h40);
        chk("R3 evict owner", {28'd0, rej_owner}, 32'd3);

        op(3'd3, 32'h0000_0001);
        chk("R9 ipi evicts", {8'd0, rej_src}, 32'h42);

        op(3'd0, 32'd0);
        chk("R5 accept word", rd_word, 32'hFF00_0002);
        chk("R5 accept lowers", {31'd0, irq_out}, 32'd0);

        op(3'd1, 32'd0);
        chk("R6 poll word", rd_word, 32'h0100_0000);
        chk("R6 poll ipi", {24'd0, rd_ipi_prio}, 32'h01);

        offer(24'h50, 8'd1, 4'd0);
        chk("R2 equal to cppr refused", {31'd0, nack_valid}, 32'd1);

        op(3'd4, 32'hFF00_0002);
        chk("R10 eoi src", {8'd0, eoi_src}, 32'h2);
        chk("R10 resend", {31'd0, resend_req}, 32'd1);
        chk("R10 ipi reloaded", {31'd0, irq_out}, 32'd1);

        op(3'd2, 32'h0000_0000);
        chk("R7 cleared", {31'd0, irq_out}, 32'd0);
        chk("R7 ipi not rejected", {31'd0, rej_valid}, 32'd0);

        step(1'b1, 24'h60, 8'd0, 4'd7, 1'b1, 3'd1, 32'd0);
        chk("R4 collision nack", {8'd0, nack_src}, 32'h60);
        chk("R4 op performed", {31'd0, rd_valid}, 32'd1);

        op(3'd2, 32'h0000_0080);
        chk("R8 ipi on relax", {31'd0, irq_out}, 32'd1);

        offer(24'h70, 8'd0, 4'd5);
        chk("R3 ipi displaced silently", {31'd0, rej_valid}, 32'd0);

        op(3'd2, 32'h0000_0010);
        chk("R7 favoured entry kept", {31'd0, irq_out}, 32'd1);

        op(3'd1, 32'd0);
        chk("R6 poll after keep", rd_word, 32'h1000_0070);

        for (int i = 0; i < 6000; i++) begin
            logic        ov, qv;
            logic [7:0]  lb, tb;
            int          r;
            r  = $urandom % 100;
            ov = (r < 45);
            qv = (($urandom % 100) < 30);
            lb = (($urandom % 12) >= 10) ? 8'hFF : 8'($urandom % 10);
            tb = (($urandom % 8) == 0) ? 8'hFF : 8'($urandom % 10);
            step(ov, 24'h100 + 24'($urandom % 16), 8'($urandom % 10), 4'($urandom % 16),
                 qv, 3'($urandom % 6), {tb, 16'h0, lb});
            if (i == 3000) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                op(3'd1, 32'd0);
                chk("R1 word after reset", rd_word, 32'h0);
                chk("R1 ipi after reset", {24'd0, rd_ipi_prio}, 32'hFF);
            end
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule